// File: doc/BRIEF.md
# Serial Pixel Deserializer with Frame Recovery

This block takes a single-wire stream of framed pixel characters at the bit rate and rebuilds a parallel pixel interface from it. Each character is twelve bits long: a start bit, a ten-bit payload and a stop bit. The block first finds the character boundaries from the start and stop bits. It then extracts the payloads and watches for a reserved three-character marker that opens a frame. The frame and line strobes are not carried in the stream. They are regenerated by a state machine and counters from the configured geometry: vertical offset, active width, horizontal blanking and active height.

Typical use is behind a serial receiver whose bit clock drives `clk`. The geometry inputs are held stable while a frame is in progress. Downstream logic consumes `pix_data` when `pix_valid` is high, and uses `line_valid` and `frame_valid` as ordinary raster strobes.

Top module: `serial_pix_deser`

## Requirements
- R1: A character is a start bit of 1, then ten payload bits with the least significant bit first, then a stop bit of 0. The payload of every active character appears unchanged on `pix_data` together with `pix_valid`.
- R2: `locked` rises only after `LOCK_CHARS` (default 3) consecutive correctly framed characters, each twelve bits after the previous one. It does not rise after fewer.
- R3: The marker is the payload sequence 0x3FF, 0x000, 0x3FF. It is accepted only when at least `MIN_IDLE` (default 4) idle characters (payload 0x000) were received while locked just before it. Otherwise it is ignored: no frame starts and no pixels are produced.
- R4: `frame_valid` rises one bit clock after the third marker character completes, with `line_valid` low. `line_valid` stays low for the next `cfg_voff` characters.
- R5: Each line is `cfg_width` active characters with `line_valid` high, followed by `cfg_hblank` characters with `line_valid` low. A frame has `cfg_height` lines, so `line_valid` rises `cfg_height` times when `cfg_hblank` is nonzero.
- R6: `frame_valid` and `line_valid` both fall when the character after the last pixel of the last line completes.
- R7: `pix_valid` is a single-cycle pulse, once per active character. It is high only while `line_valid` and `frame_valid` are high, and `line_valid` is high only while `frame_valid` is high.
- R8: A character with a bad stop bit while locked drops `locked` and clears `frame_valid` and `line_valid`. The block then hunts for alignment again and relocks on a clean stream.
- R9: After reset, `locked`, `frame_valid`, `line_valid`, `pix_valid` and `pix_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sdi | input | 1 | Serial data bit |
| cfg_width | input | CFG_W | Active characters per line (at least 1) |
| cfg_height | input | CFG_W | Active lines per frame (at least 1) |
| cfg_hblank | input | CFG_W | Blank characters after each line |
| cfg_voff | input | CFG_W | Characters between marker and first line |
| pix_data | output | 10 | Recovered pixel payload |
| pix_valid | output | 1 | One-cycle strobe per active pixel |
| frame_valid | output | 1 | Recovered frame strobe |
| line_valid | output | 1 | Recovered line strobe |
| locked | output | 1 | Character alignment established |

## Verification
The stream first carries idle characters only. This separates lock after exactly the required number of framed characters from lock one character early. A marker preceded by too few idles, followed by pixel-like data, tells an honest idle-run guard from one that accepts any marker. Two frames with different geometry, one with a nonzero vertical offset and one without, carry distinct pixel values through a scoreboard, and the line-valid rising edges are counted. This exposes off-by-one errors in the width, blanking, offset and height counters, as well as bit-order mistakes in the payload. A character with a corrupted stop bit, followed by a clean idle stream, shows that lock and the strobes drop and that alignment is recovered.

// File: rtl/sdes_pkg.sv
// Shared constants and types for the serial pixel deserializer.
// Assumes the fixed 12-bit character layout: start, 10 payload bits, stop.
package sdes_pkg;
    localparam int CHR_W = 12;
    localparam int PAY_W = 10;
    localparam logic [PAY_W-1:0] IDLE_CODE = 10'h000;
    localparam logic [PAY_W-1:0] MARK_CODE = 10'h3FF;

    typedef enum logic [2:0] {
        F_SEEK,  // counting idles, waiting for marker
        F_M1,    // saw first marker character
        F_M2,    // saw marker idle character
        F_VOFF,  // vertical offset characters
        F_ACT,   // active pixels of a line
        F_HBL,   // horizontal blanking
        F_END    // closing character after last pixel
    } frame_st_t;
endpackage

// File: rtl/sdes_align.sv
// Character aligner: hunts bit positions for a start bit (1) and stop bit (0)
// twelve bits apart. It declares lock after LOCK_CHARS consecutive framed
// characters, then emits one strobe per character with its payload.
// Assumes LOCK_CHARS >= 2 and that sdi is sampled once per clk.
module sdes_align
    import sdes_pkg::*;
#(
    parameter int LOCK_CHARS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sdi,
    output logic             chr_stb,
    output logic [PAY_W-1:0] chr_data,
    output logic             locked
);
    localparam int CNT_W  = $clog2(CHR_W);
    localparam int GOOD_W = $clog2(LOCK_CHARS + 1);
    localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(CHR_W - 1);
    localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_CHARS - 1);

    logic [CHR_W-1:0]  sr;
    logic [CHR_W-1:0]  win;
    logic [CNT_W-1:0]  cnt;
    logic [GOOD_W-1:0] good;
    logic              cand;
    logic              frame_ok;

    // Window of the last twelve bits including the current one; oldest in bit 0.
    assign win      = {sdi, sr[CHR_W-1:1]};
    assign frame_ok = win[0] & ~win[CHR_W-1];

    // Hunt, confirm and track character boundaries; emit payload strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr       <= '0;
            cnt      <= '0;
            good     <= '0;
            cand     <= 1'b0;
            locked   <= 1'b0;
            chr_stb  <= 1'b0;
            chr_data <= '0;
        end else begin
            sr      <= win;
            chr_stb <= 1'b0;
            if (!cand) begin
                if (frame_ok) begin
                    cand <= 1'b1;
                    cnt  <= '0;
                    good <= GOOD_W'(1);
                end
            end else if (cnt != LAST_BIT) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
                if (frame_ok) begin
                    if (locked) begin
                        chr_stb  <= 1'b1;
                        chr_data <= win[PAY_W:1];
                    end else if (good == GOOD_LAST) begin
                        locked <= 1'b1;
                    end else begin
                        good <= good + 1'b1;
                    end
                end else begin
                    cand   <= 1'b0;
                    locked <= 1'b0;
                    good   <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/sdes_frame.sv
// Frame rebuilder: counts idle characters, accepts the three-character marker
// after MIN_IDLE idles, then regenerates frame, line and pixel strobes from
// the geometry inputs. Acts only on character strobes; held clear while unlocked.
// Assumes cfg_width and cfg_height are at least 1 and stable during a frame.
module sdes_frame
    import sdes_pkg::*;
#(
    parameter int MIN_IDLE = 4,
    parameter int CFG_W    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             locked,
    input  logic             chr_stb,
    input  logic [PAY_W-1:0] chr_data,
    input  logic [CFG_W-1:0] cfg_width,
    input  logic [CFG_W-1:0] cfg_height,
    input  logic [CFG_W-1:0] cfg_hblank,
    input  logic [CFG_W-1:0] cfg_voff,
    output logic [PAY_W-1:0] pix_data,
    output logic             pix_valid,
    output logic             frame_valid,
    output logic             line_valid
);
    localparam int IDL_W = $clog2(MIN_IDLE + 1);
    localparam logic [IDL_W-1:0] IDLE_SAT = IDL_W'(MIN_IDLE);

    frame_st_t        st;
    logic [IDL_W-1:0] idle_cnt;
    logic [CFG_W-1:0] pos;
    logic [CFG_W-1:0] line;
    logic             is_idle;
    logic             is_mark;

    assign is_idle = (chr_data == IDLE_CODE);
    assign is_mark = (chr_data == MARK_CODE);

    // Marker search and raster regeneration, one step per received character.
    always_ff @(posedge clk) begin
        if (!rst_n || !locked) begin
            st          <= F_SEEK;
            idle_cnt    <= '0;
            pos         <= '0;
            line        <= '0;
            pix_data    <= '0;
            pix_valid   <= 1'b0;
            frame_valid <= 1'b0;
            line_valid  <= 1'b0;
        end else begin
            pix_valid <= 1'b0;
            if (chr_stb) begin
                unique case (st)
                    F_SEEK: begin
                        if (is_idle) begin
                            if (idle_cnt != IDLE_SAT) idle_cnt <= idle_cnt + 1'b1;
                        end else begin
                            idle_cnt <= '0;
                            if (is_mark && idle_cnt == IDLE_SAT) st <= F_M1;
                        end
                    end
                    F_M1: st <= is_idle ? F_M2 : F_SEEK;
                    F_M2: begin
                        if (is_mark) begin
                            frame_valid <= 1'b1;
                            pos         <= '0;
                            line        <= '0;
                            st          <= (cfg_voff == '0) ? F_ACT : F_VOFF;
                        end else begin
                            st <= F_SEEK;
                        end
                    end
                    F_VOFF: begin
                        if (pos == cfg_voff - 1'b1) begin
                            pos <= '0;
                            st  <= F_ACT;
                        end else begin
                            pos <= pos + 1'b1;
                        end
                    end
                    F_ACT: begin
                        pix_valid  <= 1'b1;
                        pix_data   <= chr_data;
                        line_valid <= 1'b1;
                        if (pos == cfg_width - 1'b1) begin
                            pos <= '0;
                            if (line == cfg_height - 1'b1) begin
                                st <= F_END;
                            end else begin
                                line <= line + 1'b1;
                                if (cfg_hblank != '0) st <= F_HBL;
                            end
                        end else begin
                            pos <= pos + 1'b1;
                        end
                    end
                    F_HBL: begin
                        line_valid <= 1'b0;
                        if (pos == cfg_hblank - 1'b1) begin
                            pos <= '0;
                            st  <= F_ACT;
                        end else begin
                            pos <= pos + 1'b1;
                        end
                    end
                    F_END: begin
                        line_valid  <= 1'b0;
                        frame_valid <= 1'b0;
                        idle_cnt    <= is_idle ? IDL_W'(1) : '0;
                        st          <= F_SEEK;
                    end
                    default: st <= F_SEEK;
                endcase
            end
        end
    end
endmodule

// File: rtl/serial_pix_deser.sv
// Top of the serial pixel deserializer: aligner feeding the frame rebuilder.
// Assumes clk runs at the serial bit rate and sdi is already retimed to it.
module serial_pix_deser
    import sdes_pkg::*;
#(
    parameter int LOCK_CHARS = 3,
    parameter int MIN_IDLE   = 4,
    parameter int CFG_W      = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sdi,
    input  logic [CFG_W-1:0] cfg_width,
    input  logic [CFG_W-1:0] cfg_height,
    input  logic [CFG_W-1:0] cfg_hblank,
    input  logic [CFG_W-1:0] cfg_voff,
    output logic [9:0]       pix_data,
    output logic             pix_valid,
    output logic             frame_valid,
    output logic             line_valid,
    output logic             locked
);
    logic             chr_stb;
    logic [PAY_W-1:0] chr_data;

    sdes_align #(.LOCK_CHARS(LOCK_CHARS)) u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .sdi      (sdi),
        .chr_stb  (chr_stb),
        .chr_data (chr_data),
        .locked   (locked)
    );

    sdes_frame #(.MIN_IDLE(MIN_IDLE), .CFG_W(CFG_W)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .locked      (locked),
        .chr_stb     (chr_stb),
        .chr_data    (chr_data),
        .cfg_width   (cfg_width),
        .cfg_height  (cfg_height),
        .cfg_hblank  (cfg_hblank),
        .cfg_voff    (cfg_voff),
        .pix_data    (pix_data),
        .pix_valid   (pix_valid),
        .frame_valid (frame_valid),
        .line_valid  (line_valid)
    );
endmodule

// File: rtl/sdes_chk.sv
// Protocol checker for the deserializer outputs, bound onto the top module.
module sdes_chk (
    input logic clk,
    input logic rst_n,
    input logic pix_valid,
    input logic line_valid,
    input logic frame_valid,
    input logic locked
);
    assert_pix_in_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (line_valid && frame_valid));

    assert_pix_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> !pix_valid);

    assert_line_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> frame_valid);

    assert_unlock_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> (!frame_valid && !line_valid));

    assert_frame_opens_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_valid) |-> !line_valid);
endmodule

bind serial_pix_deser sdes_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_valid   (pix_valid),
    .line_valid  (line_valid),
    .frame_valid (frame_valid),
    .locked      (locked)
);

// File: tb/tb_serial_pix_deser.sv
// Scoreboard bench: the driver pushes the expected pixels into a queue, and a
// monitor pops and compares them as pix_valid pulses.
module tb_serial_pix_deser;
    localparam int CFG_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sdi = 1'b0;
    logic [CFG_W-1:0] cfg_width = '0, cfg_height = '0, cfg_hblank = '0, cfg_voff = '0;
    logic [9:0]       pix_data;
    logic             pix_valid, frame_valid, line_valid, locked;

    int n_chk = 0;
    int n_bad = 0;
    int lv_rises = 0;
    logic lv_prev = 1'b0;
    logic [9:0] exp_q [$];

    always #2 clk = ~clk;

    serial_pix_deser dut (
        .clk(clk), .rst_n(rst_n), .sdi(sdi),
        .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_hblank(cfg_hblank), .cfg_voff(cfg_voff),
        .pix_data(pix_data), .pix_valid(pix_valid),
        .frame_valid(frame_valid), .line_valid(line_valid), .locked(locked)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) sdi <= b;
        @(posedge clk);
        #1;
    endtask

    // R1: start 1, payload LSB first, stop bit (0 when well formed).
    task automatic send_char(input logic [9:0] p, input logic stop = 1'b0);
        send_bit(1'b1);
        for (int i = 0; i < 10; i++) send_bit(p[i]);
        send_bit(stop);
    endtask

    task automatic send_idles(input int n);
        for (int i = 0; i < n; i++) send_char(10'h000);
    endtask

    task automatic send_marker();
        send_char(10'h3FF);
        send_char(10'h000);
        send_char(10'h3FF);
    endtask

    // Sends one frame body after the marker and pushes the expected pixels.
    task automatic send_frame(input int w, input int h, input int hb, input int vo, input int seed);
        for (int i = 0; i < vo; i++) send_char(10'h000);
        for (int l = 0; l < h; l++) begin
            for (int x = 0; x < w; x++) begin
                logic [9:0] v;
                v = 10'(seed + 37 * l + 5 * x);
                exp_q.push_back(v);
                send_char(v);
            end
            if (l != h - 1) for (int b = 0; b < hb; b++) send_char(10'h000);
        end
    endtask

    // Monitor: compare each pixel against the scoreboard; count line starts.
    always @(negedge clk) begin
        if (rst_n) begin
            if (line_valid && !lv_prev) lv_rises++;
            lv_prev = line_valid;
            if (pix_valid) begin
                if (exp_q.size() == 0) begin
                    chk("R3 unexpected pixel", 1, 0);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    chk("R1 pixel payload", int'(pix_data), int'(e));
                    chk("R7 pixel inside line", int'(line_valid && frame_valid), 1);
                end
            end
        end
    end

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R9: reset state
        chk("R9 reset outputs", int'({locked, frame_valid, line_valid, pix_valid, pix_data != 0}), 0);
        @(negedge clk) rst_n <= 1'b1;

        // R2: lock after exactly three framed characters
        send_idles(2);
        chk("R2 no early lock", int'(locked), 0);
        send_idles(1);
        chk("R2 lock after three", int'(locked), 1);

        // R3: marker after only two idles is ignored
        cfg_width = 4; cfg_height = 3; cfg_hblank = 2; cfg_voff = 3;
        send_idles(2);
        send_marker();
        send_char(10'h123);
        send_char(10'h0AB);
        chk("R3 short idle run ignored", int'(frame_valid), 0);
        send_char(10'h155);
        chk("R3 no line after ignored marker", lv_rises, 0);

        // Frame one: offset 3, width 4, blank 2, height 3
        lv_rises = 0;
        send_idles(5);
        send_marker();
        send_char(10'h000);
        chk("R4 frame opens on marker", int'(frame_valid), 1);
        chk("R4 line low in offset", int'(line_valid), 0);
        send_frame(4, 3, 2, 2, 100);
        chk("R5 frame running at last pixel", int'(frame_valid), 1);
        send_char(10'h000);
        send_char(10'h000);
        chk("R6 frame closes", int'(frame_valid), 0);
        chk("R6 line closes", int'(line_valid), 0);
        chk("R5 line count frame one", lv_rises, 3);
        chk("R5 scoreboard drained", exp_q.size(), 0);

        // Frame two: no offset, width 3, blank 1, height 2
        cfg_width = 3; cfg_height = 2; cfg_hblank = 1; cfg_voff = 0;
        lv_rises = 0;
        send_idles(4);
        send_marker();
        chk("R4 frame rises no offset", int'(frame_valid), 0);
        send_frame(3, 2, 1, 0, 400);
        send_idles(2);
        chk("R5 line count frame two", lv_rises, 2);
        chk("R6 frame two closed", int'(frame_valid), 0);
        chk("R5 scoreboard drained two", exp_q.size(), 0);

        // R8: stop-bit error during a frame drops lock and strobes
        cfg_width = 8; cfg_height = 4; cfg_hblank = 1; cfg_voff = 1;
        send_idles(4);
        send_marker();
        send_char(10'h000);
        chk("R8 frame active before error", int'(frame_valid), 1);
        send_char(10'h0F0, 1'b1);
        chk("R8 lock dropped", int'(locked), 0);
        send_bit(1'b0);
        send_bit(1'b0);
        chk("R8 frame cleared", int'(frame_valid), 0);
        chk("R8 line cleared", int'(line_valid), 0);
        send_idles(8);
        chk("R8 relock", int'(locked), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule